// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the byte-wide on-chip data store of a small 8-bit microcontroller core. The core's decoder issues one request per clock on a synchronous port: an access kind, an 8-bit address, write data and a single bit value. The unit resolves the request to one of three targets. These are the lower 128 bytes of RAM, the upper 128 bytes of RAM, or the special-function register (SFR) space. Reads complete with a fixed latency of one clock.

Four addressing paths are supported. A register-operand access names register n (0 to 7) inside the currently selected bank. The selected bank comes from two bank-select bits of an internal status register. A direct access and an indirect access both reach the lower RAM for addresses below 80h, but they split above it. Direct accesses go to SFR space. Indirect accesses go to the separate upper RAM. A bit access maps a 7-bit bit address onto the bit-addressable window at bytes 20h to 2Fh. A bit write is a read-modify-write inside a single clock.

The status register lives at direct address D0h and stays inside the unit. Every other direct SFR access is passed to an external SFR port as a strobe, an address and write data. The external side returns read data combinationally in the same cycle.

Top module: `banked_dmem`

## Requirements
- R1: While reset is held and in the first cycle after it, rvalid, err and rdata are all zero. The status register is 00h, so bank 0 is selected and every RAM byte reads 00h.
- R2: Kind 0 (register read) and kind 1 (register write) use req_addr[2:0] as the register number n. They access lower-RAM byte 8*bank+n, where bank is {status[4], status[3]}.
- R3: Kind 2 (direct read) and kind 3 (direct write) at address D0h read or write the internal status register. No SFR strobe is raised. A bank change made this way applies to the next register access.
- R4: For addresses 00h to 7Fh, kinds 2/3 and kinds 4/5 (indirect read/write) reach the same lower-RAM byte.
- R5: Kinds 2/3 at any address from 80h to FFh other than D0h raise sfr_rd or sfr_wr in the same cycle as the request, with sfr_addr = req_addr and sfr_wdata = req_wdata. A direct read then returns the sfr_rdata value of that cycle.
- R6: Kinds 4/5 at addresses 80h to FFh reach a 128-byte upper RAM that is separate from SFR space. They raise no SFR strobe.
- R7: Kind 6 (bit read) at bit address b below 80h returns bit (b & 7) of byte 20h + (b >> 3) in rdata[0], with rdata[7:1] = 0.
- R8: Kind 7 (bit write) at b below 80h sets that bit to req_bit. All other bits of the byte are left unchanged.
- R9: A kind 6 or 7 request with b of 80h or above raises err exactly one cycle later with rvalid low. It changes no storage.
- R10: Every accepted read raises rvalid exactly one cycle after the request. A write followed in the next cycle by a read of the same location returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind 0..7 (even = read, odd = write) |
| req_addr | input | 8 | Register number, byte address or bit address |
| req_wdata | input | 8 | Byte write data |
| req_bit | input | 1 | Bit write value |
| rdata | output | 8 | Read data, valid when rvalid |
| rvalid | output | 1 | Read data returned this cycle |
| err | output | 1 | Rejected bit access one cycle earlier |
| sfr_rd | output | 1 | External SFR read strobe |
| sfr_wr | output | 1 | External SFR write strobe |
| sfr_addr | output | 8 | External SFR address |
| sfr_wdata | output | 8 | External SFR write data |
| sfr_rdata | input | 8 | External SFR read data, same cycle |

## Verification
A wrong bank value does not show on its own. It shows only at the next register read, when rdata arrives one clock later holding a byte from the wrong bank. A corrupted bit write or a stray write from a rejected bit access stays hidden until the affected byte or bit is read back. For that reason the stimulus interleaves writes with reads of neighbouring bits and of aliases in every address space. A misrouted upper address shows up at once as a wrong SFR strobe in the request cycle, or as upper-RAM data where SFR data was due.

// File: rtl/banked_dmem.sv
module banked_dmem #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [7:0] STATUS_ADDR = 8'hD0,
  parameter int BANK_BIT = 3,
  parameter logic [6:0] BIT_BASE = 7'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_bit,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int HALF = 2 ** (AW - 1);
  localparam int IW = AW - 1;

  logic [DW-1:0] lo_mem [HALF];
  logic [DW-1:0] hi_mem [HALF];
  logic [DW-1:0] status_q;

  wire is_reg = req_kind[2:1] == 2'd0;
  wire is_dir = req_kind[2:1] == 2'd1;
  wire is_ind = req_kind[2:1] == 2'd2;
  wire is_bit = req_kind[2:1] == 2'd3;
  wire is_wr  = req_kind[0];
  wire upper  = req_addr[AW-1];

  wire bad_bit    = is_bit & upper;
  wire status_sel = is_dir & (req_addr == STATUS_ADDR);
  wire sfr_sel    = is_dir & upper & ~status_sel;
  wire hi_sel     = is_ind & upper;
  wire lo_sel     = is_reg | (~upper & (is_dir | is_ind | is_bit));

  logic [IW-1:0] lo_idx;
  always_comb begin
    if (is_reg)
      lo_idx = IW'({status_q[BANK_BIT+1:BANK_BIT], req_addr[2:0]});
    else if (is_bit)
      lo_idx = IW'(BIT_BASE) + IW'(req_addr[IW-1:3]);
    else
      lo_idx = req_addr[IW-1:0];
  end

  wire [DW-1:0] lo_byte = lo_mem[lo_idx];
  wire          bit_val = lo_byte[req_addr[2:0]];

  logic [DW-1:0] bit_merged;
  always_comb begin
    bit_merged = lo_byte;
    bit_merged[req_addr[2:0]] = req_bit;
  end

  assign sfr_rd    = req_valid & sfr_sel & ~is_wr;
  assign sfr_wr    = req_valid & sfr_sel & is_wr;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      for (int i = 0; i < HALF; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
      end
    end else if (req_valid && is_wr && !bad_bit) begin
      if (status_sel) status_q <= req_wdata;
      if (hi_sel) hi_mem[req_addr[IW-1:0]] <= req_wdata;
      if (lo_sel) lo_mem[lo_idx] <= is_bit ? bit_merged : req_wdata;
    end
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    if (is_bit)          rd_next = {{(DW-1){1'b0}}, bit_val};
    else if (status_sel) rd_next = status_q;
    else if (sfr_sel)    rd_next = sfr_rdata;
    else if (hi_sel)     rd_next = hi_mem[req_addr[IW-1:0]];
    else                 rd_next = lo_byte;
  end

  wire rd_ok = req_valid & ~is_wr & ~bad_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_ok;
      err    <= req_valid & bad_bit;
      if (rd_ok) rdata <= rd_next;
    end
  end

  assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3 && req_addr == STATUS_ADDR) |=> status_q == $past(req_wdata));

  assert_sfr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> (req_addr[AW-1] && req_addr != STATUS_ADDR && req_kind[2:1] == 2'd1));

  assert_ind_no_sfr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[2:1] == 2'd2) |-> !(sfr_rd || sfr_wr));

  assert_bad_bit_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[2:1] == 2'd3 && req_addr[AW-1]) |=> (err && !rvalid));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind[0] && !(req_kind[2:1] == 2'd3 && req_addr[AW-1])) |=> rvalid);

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_kind[2:1] == 2'd3 && req_addr[AW-1]) |=> !err);
endmodule

// File: tb/tb_banked_dmem.sv
module tb_banked_dmem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_bit = 1'b0;
  logic [7:0] rdata;
  logic rvalid, err, sfr_rd, sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

  always #10 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'h5A;

  banked_dmem dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .rdata(rdata), .rvalid(rvalid), .err(err), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [7:0] m_lo [128];
  logic [7:0] m_hi [128];
  logic [7:0] m_status;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] k, logic [7:0] a);
    case (k[2:1])
      2'd0: return "R2";
      2'd1: return (a == 8'hD0) ? "R3" : (a[7] ? "R5" : "R4");
      2'd2: return a[7] ? "R6" : "R4";
      default: return a[7] ? "R9" : (k[0] ? "R8" : "R7");
    endcase
  endfunction

  task automatic step(logic [2:0] k, logic [7:0] a, logic [7:0] wd, logic bv, string req);
    logic exp_rv, exp_err, exp_srd, exp_swr;
    logic [7:0] exp_rd;
    logic [6:0] idx;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_bit = bv;
    #1;
    exp_srd = (k == 3'd2) && a[7] && a != 8'hD0;
    exp_swr = (k == 3'd3) && a[7] && a != 8'hD0;
    check({req, " strobe"}, {30'd0, sfr_rd, sfr_wr}, {30'd0, exp_srd, exp_swr});
    if (exp_srd || exp_swr) check({req, " sfr addr/data"}, {16'd0, sfr_addr, sfr_wdata}, {16'd0, a, wd});
    exp_rv = 1'b0; exp_err = 1'b0; exp_rd = 8'h00;
    case (k)
      3'd0: begin exp_rv = 1; exp_rd = m_lo[{m_status[4:3], a[2:0]}]; end
      3'd1: m_lo[{m_status[4:3], a[2:0]}] = wd;
      3'd2: begin
        exp_rv = 1;
        if (!a[7]) exp_rd = m_lo[a[6:0]];
        else if (a == 8'hD0) exp_rd = m_status;
        else exp_rd = a ^ 8'h5A;
      end
      3'd3: begin
        if (!a[7]) m_lo[a[6:0]] = wd;
        else if (a == 8'hD0) m_status = wd;
      end
      3'd4: begin exp_rv = 1; exp_rd = a[7] ? m_hi[a[6:0]] : m_lo[a[6:0]]; end
      3'd5: if (a[7]) m_hi[a[6:0]] = wd; else m_lo[a[6:0]] = wd;
      3'd6: begin
        idx = 7'h20 + 7'(a[6:3]);
        if (a[7]) exp_err = 1;
        else begin exp_rv = 1; exp_rd = {7'd0, m_lo[idx][a[2:0]]}; end
      end
      default: begin
        idx = 7'h20 + 7'(a[6:3]);
        if (a[7]) exp_err = 1;
        else m_lo[idx][a[2:0]] = bv;
      end
    endcase
    @(negedge clk);
    check({req, " rvalid/err"}, {30'd0, rvalid, err}, {30'd0, exp_rv, exp_err});
    if (exp_rv) check({req, " rdata"}, {24'd0, rdata}, {24'd0, exp_rd});
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_lo[i] = 8'h00; m_hi[i] = 8'h00; end
    m_status = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {22'd0, rdata, rvalid, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {22'd0, rdata, rvalid, err}, 32'd0);
    step(3'd0, 8'h00, 8'h00, 0, "R1 bank0 R0 zero");
    step(3'd2, 8'hD0, 8'h00, 0, "R1 status zero");

    for (int n = 0; n < 8; n++) step(3'd1, 8'(n), 8'(8'h10 + n), 0, "R2 bank0 write");
    step(3'd3, 8'hD0, 8'h08, 0, "R3 select bank1");
    step(3'd1, 8'h03, 8'hB3, 0, "R2 bank1 R3 write");
    step(3'd0, 8'h03, 8'h00, 0, "R2 bank1 R3 read");
    step(3'd2, 8'h0B, 8'h00, 0, "R2 bank1 alias direct");
    step(3'd3, 8'hD0, 8'h18, 0, "R3 select bank3");
    step(3'd0, 8'h07, 8'h00, 0, "R3 bank switch next cycle");
    step(3'd3, 8'hD0, 8'hE7, 0, "R3 other bits bank0");
    step(3'd0, 8'h05, 8'h00, 0, "R2 bank0 R5");
    step(3'd2, 8'hD0, 8'h00, 0, "R3 status readback");

    step(3'd3, 8'h40, 8'hA5, 0, "R4 direct write");
    step(3'd4, 8'h40, 8'h00, 0, "R4 indirect read alias");
    step(3'd5, 8'h7F, 8'h3C, 0, "R4 indirect write top");
    step(3'd2, 8'h7F, 8'h00, 0, "R4 direct read top");

    step(3'd5, 8'h90, 8'h77, 0, "R6 upper write");
    step(3'd3, 8'h90, 8'h11, 0, "R5 direct write to sfr");
    step(3'd4, 8'h90, 8'h00, 0, "R6 upper read unaffected");
    step(3'd2, 8'h90, 8'h00, 0, "R5 sfr read");
    step(3'd5, 8'hD0, 8'h99, 0, "R6 upper at D0");
    step(3'd2, 8'hD0, 8'h00, 0, "R6 status not hit");
    step(3'd4, 8'hD0, 8'h00, 0, "R6 upper D0 read");

    step(3'd3, 8'h2F, 8'h00, 0, "R8 clear byte 2F");
    step(3'd7, 8'h7F, 8'h00, 1, "R8 set MSB 2F");
    step(3'd2, 8'h2F, 8'h00, 0, "R7 byte 2F");
    step(3'd3, 8'h20, 8'hFF, 0, "R8 fill byte 20");
    step(3'd7, 8'h00, 8'h00, 0, "R8 clear LSB 20");
    step(3'd2, 8'h20, 8'h00, 0, "R8 only LSB cleared");
    step(3'd6, 8'h01, 8'h00, 0, "R7 bit 01");
    step(3'd6, 8'h00, 8'h00, 0, "R7 bit 00");
    step(3'd7, 8'h85, 8'h00, 0, "R9 rejected write");
    step(3'd6, 8'h05, 8'h00, 0, "R9 no stray change");
    step(3'd6, 8'hF3, 8'h00, 0, "R9 rejected read");
    idle();
    check("R9 err one cycle", {31'd0, err}, 32'd0);

    step(3'd5, 8'h55, 8'hC3, 0, "R10 write");
    step(3'd4, 8'h55, 8'h00, 0, "R10 read after write");
    step(3'd7, 8'h3A, 8'h00, 1, "R10 bit write");
    step(3'd6, 8'h3A, 8'h00, 0, "R10 bit read after write");

    for (int i = 0; i < 2000; i++) begin
      logic [2:0] k;
      logic [7:0] a;
      k = 3'($urandom_range(0, 7));
      a = 8'($urandom);
      if ($urandom_range(0, 3) == 0) a[7] = 1'b0;
      if (k == 3'd3 && a == 8'hD0 && $urandom_range(0, 1) == 0) a = 8'hCF;
      step(k, a, 8'($urandom), 1'($urandom), tag_of(k, a));
      if ($urandom_range(0, 15) == 0) idle();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule